// File: doc/BRIEF.md
# Vector Agnostic-Policy Fill Unit

This block sits after the result write path of a vector unit and patches one destination register before it is committed. Masked-off body elements and tail elements that the vector policy allows to be overwritten are forced to all-ones. This makes agnostic behaviour visible and repeatable, rather than leaving stale data behind. The caller supplies the computed register value, the v0 mask (or the selector register for compress), vl, vstart, the SEW code, the vm/vma/vta bits, the load width field, an instruction-class code from the decoder, and the index of this register within its group.

The tail start point depends on the class. Ordinary arithmetic starts at vl. Mask loads start at vl/8 bytes. Scalar moves start at element 1. Compress starts at the number of selected mask bits. Mask-writing operations work at bit granularity. A request is accepted in one cycle, and the patched value is presented in a register together with a one-cycle done pulse.

Top module: `agnostic_fill_unit`

## Requirements
- R1: in_ready is always high, and a request is accepted when in_valid is high. out_done is high exactly in the cycle after an accepted request, with out_vd holding the patched value. After reset, out_done is 0 and out_vd is 0.
- R2: Class codes 3 (store), 2 (scalar destination) and 7 (whole-register move or load) return in_vd unchanged, whatever the policy bits are.
- R3: No bit changes when vstart is greater than or equal to the effective length, or when the effective length is 0. The effective length is vl, except for class 6, where it is vl/8.
- R4: For class 0 (arithmetic), with in_vm=0 and in_vma=1, every element whose index g satisfies vstart <= g < vl and whose mask bit g is 0 becomes all-ones. Element width is 8 << in_sew (codes 0..3 give 8, 16, 32 and 64). No mask fill takes place when in_vm=1 or in_vma=0.
- R5: For class 0 with in_vta=1, every element with index >= vl in the register becomes all-ones. With in_vta=0, the tail is left undisturbed.
- R6: For element-indexed classes (0, 4, 5, 9), the element at local position k of the register has global index in_roff*(VLEN/width)+k. This applies, for example, to class 0.
- R7: For class 1 (mask-writing operations), bits vl..VLEN-1 are set to 1 regardless of vta. With vm=0 and vma=1, body bits whose mask bit is 0 are also set to 1.
- R8: For class 6 (mask load), bytes from floor(vl/8) up to the end of the register are set to all-ones regardless of vta.
- R9: For class 8 (scalar move into element 0), when vta=1 the elements 1 through VLEN/SEW-1 become all-ones, and in_roff is ignored.
- R10: For class 9 (compress), when vta=1 the tail starts at the count of 1 bits among mask bits 0..vl-1.
- R11: For class 4 (unit-stride or strided load), the element width comes from in_width: 000 gives 8, 101 gives 16, 110 gives 32 and 111 gives 64. The tail from vl is filled regardless of vta, and no mask fill is applied. Any other width code passes the value through.
- R12: For class 5 (indexed load), the element width is SEW, the tail from vl is filled regardless of vta, and no mask fill is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request may be accepted |
| in_vd | input | VLEN | Computed destination register value |
| in_mask | input | VLEN | v0 mask, or selector register for compress |
| in_vl | input | log2(VLEN)+1 | Vector length |
| in_vstart | input | log2(VLEN)+1 | First body element |
| in_sew | input | 2 | Element width code |
| in_vm | input | 1 | 1 = unmasked instruction |
| in_vma | input | 1 | Mask-agnostic policy bit |
| in_vta | input | 1 | Tail-agnostic policy bit |
| in_width | input | 3 | Load width field |
| in_class | input | 4 | Instruction class code |
| in_roff | input | 3 | Register index within the group |
| out_vd | output | VLEN | Patched register value |
| out_done | output | 1 | Result valid pulse |

## Verification
The bench builds the block with VLEN at 128. At this size, a SEW of 64 gives only two elements per register, so a single element covers half the value. Register offsets 1 and 3 move the global indices well past vl, and a vl of 31 exercises the floor of the mask-load length. Within this range, every tail start rule, both granularities and the skip conditions are checked, including vl of 0 and vstart equal to vl.

// File: rtl/agf_pkg.sv
package agf_pkg;

  typedef enum logic [3:0] {
    CLS_ARITH    = 4'd0,
    CLS_MASKW    = 4'd1,
    CLS_XDEST    = 4'd2,
    CLS_STORE    = 4'd3,
    CLS_LDSTR    = 4'd4,
    CLS_LDIDX    = 4'd5,
    CLS_LDMASK   = 4'd6,
    CLS_WHOLE    = 4'd7,
    CLS_SMOVE    = 4'd8,
    CLS_COMPRESS = 4'd9
  } op_class_e;

  // load width field -> log2(bytes per element)
  function automatic logic [1:0] width_to_shift(input logic [2:0] f);
    case (f)
      3'b101:  return 2'd1;
      3'b110:  return 2'd2;
      3'b111:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic width_is_data(input logic [2:0] f);
    return (f == 3'b000) || (f == 3'b101) || (f == 3'b110) || (f == 3'b111);
  endfunction

  function automatic logic class_is_passthru(input logic [3:0] c);
    return (c == CLS_STORE) || (c == CLS_XDEST) || (c == CLS_WHOLE);
  endfunction

endpackage

// File: rtl/agf_sel_count.sv
module agf_sel_count #(
  parameter int unsigned VLEN = 128,
  localparam int unsigned VLW = $clog2(VLEN) + 1
) (
  input  logic [VLEN-1:0] sel,
  input  logic [VLW-1:0]  vl,
  output logic [VLW-1:0]  count
);
  always_comb begin
    count = '0;
    for (int unsigned i = 0; i < VLEN; i++) begin
      if ((VLW'(i) < vl) && sel[i]) count = count + VLW'(1);
    end
  end
endmodule

// File: rtl/agf_tail_point.sv
module agf_tail_point
  import agf_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  localparam int unsigned VLW = $clog2(VLEN) + 1,
  localparam int unsigned GW  = $clog2(VLEN) + 4
) (
  input  op_class_e       cls,
  input  logic [VLW-1:0]  vl,
  input  logic [VLW-1:0]  vstart,
  input  logic [1:0]      sew,
  input  logic            vm,
  input  logic            vma,
  input  logic            vta,
  input  logic [2:0]      width,
  input  logic [2:0]      roff,
  input  logic [VLW-1:0]  sel_count,
  output logic            bit_mode,
  output logic [1:0]      elem_shift,
  output logic [GW-1:0]   base,
  output logic            ma_en,
  output logic            ta_en,
  output logic [GW-1:0]   tail_from
);
  localparam int unsigned LB = $clog2(VLEN / 8);

  logic [VLW-1:0] evl;
  logic           active;
  logic           use_roff;
  logic           ma_raw;
  logic           ta_raw;

  always_comb begin
    evl        = (cls == CLS_LDMASK) ? (vl >> 3) : vl;
    active     = (evl != '0) && (vstart < evl);
    bit_mode   = 1'b0;
    elem_shift = sew;
    use_roff   = 1'b1;
    ma_raw     = 1'b0;
    ta_raw     = 1'b0;
    tail_from  = GW'(vl);
    case (cls)
      CLS_ARITH: begin
        ma_raw = !vm && vma;
        ta_raw = vta;
      end
      CLS_MASKW: begin
        bit_mode = 1'b1;
        use_roff = 1'b0;
        ma_raw   = !vm && vma;
        ta_raw   = 1'b1;
      end
      CLS_LDSTR: begin
        elem_shift = width_to_shift(width);
        ta_raw     = width_is_data(width);
      end
      CLS_LDIDX: ta_raw = 1'b1;
      CLS_LDMASK: begin
        elem_shift = 2'd0;
        use_roff   = 1'b0;
        ta_raw     = 1'b1;
        tail_from  = GW'(evl);
      end
      CLS_SMOVE: begin
        use_roff  = 1'b0;
        ta_raw    = vta;
        tail_from = GW'(1);
      end
      CLS_COMPRESS: begin
        ta_raw    = vta;
        tail_from = GW'(sel_count);
      end
      default: ;
    endcase
    ma_en = ma_raw && active;
    ta_en = ta_raw && active;
    base  = use_roff ? ((GW'(roff) << LB) >> elem_shift) : '0;
  end
endmodule

// File: rtl/agf_fill_map.sv
module agf_fill_map #(
  parameter int unsigned VLEN = 128,
  localparam int unsigned VLW = $clog2(VLEN) + 1,
  localparam int unsigned GW  = $clog2(VLEN) + 4
) (
  input  logic [VLEN-1:0] mask,
  input  logic [VLW-1:0]  vl,
  input  logic [VLW-1:0]  vstart,
  input  logic            bit_mode,
  input  logic [1:0]      elem_shift,
  input  logic [GW-1:0]   base,
  input  logic            ma_en,
  input  logic            ta_en,
  input  logic [GW-1:0]   tail_from,
  output logic [VLEN-1:0] fill
);
  localparam int unsigned NB  = VLEN / 8;
  localparam int unsigned LIW = $clog2(VLEN);

  logic [NB-1:0]   byte_fill;
  logic [VLEN-1:0] bit_fill;

  function automatic logic mask_at(input logic [GW-1:0] g);
    return (g < GW'(VLEN)) ? mask[g[LIW-1:0]] : 1'b1;
  endfunction

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [GW-1:0] gidx;
    always_comb begin
      gidx = base + (GW'(b) >> elem_shift);
      byte_fill[b] = (ma_en && (gidx >= GW'(vstart)) && (gidx < GW'(vl)) && !mask_at(gidx))
                  || (ta_en && (gidx >= tail_from));
    end
    assign fill[8*b +: 8] = bit_mode ? bit_fill[8*b +: 8] : {8{byte_fill[b]}};
  end

  for (genvar i = 0; i < VLEN; i++) begin : g_bit
    assign bit_fill[i] = (ma_en && (VLW'(i) >= vstart) && (VLW'(i) < vl) && !mask[i])
                      || (ta_en && (GW'(i) >= tail_from));
  end
endmodule

// File: rtl/agnostic_fill_unit.sv
module agnostic_fill_unit
  import agf_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  localparam int unsigned VLW = $clog2(VLEN) + 1,
  localparam int unsigned GW  = $clog2(VLEN) + 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] in_vd,
  input  logic [VLEN-1:0] in_mask,
  input  logic [VLW-1:0]  in_vl,
  input  logic [VLW-1:0]  in_vstart,
  input  logic [1:0]      in_sew,
  input  logic            in_vm,
  input  logic            in_vma,
  input  logic            in_vta,
  input  logic [2:0]      in_width,
  input  logic [3:0]      in_class,
  input  logic [2:0]      in_roff,
  output logic [VLEN-1:0] out_vd,
  output logic            out_done
);
  op_class_e       cls_e;
  logic            fire;
  logic [VLW-1:0]  sel_count;
  logic            bit_mode;
  logic [1:0]      elem_shift;
  logic [GW-1:0]   base;
  logic            ma_en;
  logic            ta_en;
  logic [GW-1:0]   tail_from;
  logic [VLEN-1:0] fill_bits;

  assign cls_e    = op_class_e'(in_class);
  assign in_ready = 1'b1;
  assign fire     = in_valid && in_ready;

  agf_sel_count #(.VLEN(VLEN)) u_count (
    .sel   (in_mask),
    .vl    (in_vl),
    .count (sel_count)
  );

  agf_tail_point #(.VLEN(VLEN)) u_point (
    .cls        (cls_e),
    .vl         (in_vl),
    .vstart     (in_vstart),
    .sew        (in_sew),
    .vm         (in_vm),
    .vma        (in_vma),
    .vta        (in_vta),
    .width      (in_width),
    .roff       (in_roff),
    .sel_count  (sel_count),
    .bit_mode   (bit_mode),
    .elem_shift (elem_shift),
    .base       (base),
    .ma_en      (ma_en),
    .ta_en      (ta_en),
    .tail_from  (tail_from)
  );

  agf_fill_map #(.VLEN(VLEN)) u_map (
    .mask       (in_mask),
    .vl         (in_vl),
    .vstart     (in_vstart),
    .bit_mode   (bit_mode),
    .elem_shift (elem_shift),
    .base       (base),
    .ma_en      (ma_en),
    .ta_en      (ta_en),
    .tail_from  (tail_from),
    .fill       (fill_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vd   <= '0;
      out_done <= 1'b0;
    end else begin
      out_done <= fire;
      if (fire) out_vd <= in_vd | fill_bits;
    end
  end

  // R1: done pulse follows acceptance by one cycle
  a_r1_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_done);
  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !out_done);

  // R4/R5: filling only ever raises bits of the incoming value
  a_r4_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((out_vd & $past(in_vd)) == $past(in_vd)));

  // R2: pass-through classes
  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && class_is_passthru(in_class)) |=> (out_vd == $past(in_vd)));

  // R3: no body means no writes at all
  a_r3_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_vstart >= in_vl)) |=> (out_vd == $past(in_vd)));

  // R5: undisturbed arithmetic
  a_r5_undisturbed: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_class == CLS_ARITH) && (in_vm || !in_vma) && !in_vta)
      |=> (out_vd == $past(in_vd)));

  // R7: mask-writing ops always set the top bit when vl leaves a tail
  a_r7_mask_tail_top: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (in_class == CLS_MASKW) && (in_vstart < in_vl) && (in_vl < VLW'(VLEN)))
      |=> out_vd[VLEN-1]);
endmodule

// File: tb/agnostic_fill_unit_bench.sv
module agnostic_fill_unit_bench;
  localparam int VLEN = 128;
  localparam int N    = 20;

  typedef struct packed {
    logic [127:0] vd;
    logic [127:0] mask;
    logic [7:0]   vl;
    logic [7:0]   vstart;
    logic [1:0]   sew;
    logic         vm;
    logic         vma;
    logic         vta;
    logic [2:0]   width;
    logic [3:0]   cls;
    logic [2:0]   roff;
  } vec_t;

  // vd, mask, vl, vstart, sew, vm, vma, vta, width, class, roff
  localparam vec_t VECS [N] = '{
    '{128'h2, 128'h1, 8'd3, 8'd0, 2'd2, 1'b0, 1'b1, 1'b0, 3'b000, 4'd0, 3'd0},
    '{128'h3, 128'h1, 8'd3, 8'd0, 2'd2, 1'b0, 1'b0, 1'b1, 3'b000, 4'd0, 3'd0},
    '{128'h0123456789abcdef_fedcba9876543210, 128'h1, 8'd3, 8'd0, 2'd2, 1'b0, 1'b0, 1'b0, 3'b000, 4'd0, 3'd0},
    '{128'h0, 128'h0, 8'd20, 8'd0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b000, 4'd0, 3'd1},
    '{128'h0, 128'h0, 8'd14, 8'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'b000, 4'd1, 3'd0},
    '{128'h0, 128'hF0, 8'd8, 8'd0, 2'd0, 1'b0, 1'b1, 1'b0, 3'b000, 4'd1, 3'd0},
    '{128'h123456, 128'h0, 8'd31, 8'd0, 2'd2, 1'b1, 1'b0, 1'b0, 3'b000, 4'd6, 3'd0},
    '{128'h55, 128'h0, 8'd5, 8'd0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b000, 4'd6, 3'd0},
    '{128'h1234, 128'h0, 8'd4, 8'd0, 2'd1, 1'b1, 1'b0, 1'b1, 3'b000, 4'd8, 3'd3},
    '{128'h0, 128'h0D, 8'd8, 8'd0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b000, 4'd9, 3'd0},
    '{128'h77, 128'h0D, 8'd5, 8'd0, 2'd0, 1'b0, 1'b1, 1'b0, 3'b101, 4'd4, 3'd0},
    '{128'h77, 128'h0, 8'd5, 8'd0, 2'd0, 1'b1, 1'b0, 1'b1, 3'b001, 4'd4, 3'd0},
    '{128'h0, 128'h0, 8'd6, 8'd0, 2'd2, 1'b1, 1'b0, 1'b0, 3'b000, 4'd5, 3'd1},
    '{128'h99, 128'h0, 8'd3, 8'd0, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 4'd3, 3'd0},
    '{128'h99, 128'h0, 8'd3, 8'd0, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 4'd7, 3'd0},
    '{128'h99, 128'h0, 8'd3, 8'd0, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 4'd2, 3'd0},
    '{128'h11, 128'h0, 8'd5, 8'd5, 2'd0, 1'b0, 1'b1, 1'b1, 3'b000, 4'd0, 3'd0},
    '{128'h0, 128'h0, 8'd10, 8'd4, 2'd0, 1'b0, 1'b1, 1'b0, 3'b000, 4'd0, 3'd0},
    '{128'h42, 128'h0, 8'd1, 8'd0, 2'd3, 1'b1, 1'b0, 1'b1, 3'b000, 4'd0, 3'd0},
    '{128'h11, 128'h0, 8'd0, 8'd0, 2'd2, 1'b0, 1'b1, 1'b1, 3'b000, 4'd0, 3'd0}
  };
  localparam string TAGS [N] = '{"R4", "R5", "R5", "R6", "R7", "R7", "R8", "R8", "R9", "R10",
                                  "R11", "R11", "R12", "R2", "R2", "R2", "R3", "R4", "R5", "R3"};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [127:0]   in_vd = '0;
  logic [127:0]   in_mask = '0;
  logic [7:0]     in_vl = '0;
  logic [7:0]     in_vstart = '0;
  logic [1:0]     in_sew = '0;
  logic           in_vm = 1'b1;
  logic           in_vma = 1'b0;
  logic           in_vta = 1'b0;
  logic [2:0]     in_width = '0;
  logic [3:0]     in_class = '0;
  logic [2:0]     in_roff = '0;
  logic [127:0]   out_vd;
  logic           out_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  agnostic_fill_unit #(.VLEN(VLEN)) u_agnostic_fill_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vd(in_vd), .in_mask(in_mask), .in_vl(in_vl), .in_vstart(in_vstart),
    .in_sew(in_sew), .in_vm(in_vm), .in_vma(in_vma), .in_vta(in_vta),
    .in_width(in_width), .in_class(in_class), .in_roff(in_roff),
    .out_vd(out_vd), .out_done(out_done)
  );

  // Reference: walk every bit, decide which element it belongs to.
  function automatic logic [127:0] expect_of(input vec_t v);
    logic [127:0] r;
    int ew, n, base, evl, tfrom, cnt, g;
    bit mfill, tfill, bitwise;
    r = v.vd;
    evl = (v.cls == 4'd6) ? int'(v.vl) / 8 : int'(v.vl);
    if (evl == 0 || int'(v.vstart) >= evl) return r;
    ew = 8 << v.sew; base = 0; mfill = 0; tfill = 0; bitwise = 0; tfrom = int'(v.vl);
    case (v.cls)
      4'd0: begin mfill = !v.vm && v.vma; tfill = v.vta; base = -1; end
      4'd1: begin bitwise = 1; mfill = !v.vm && v.vma; tfill = 1; end
      4'd4: begin
        case (v.width)
          3'b000: ew = 8; 3'b101: ew = 16; 3'b110: ew = 32; 3'b111: ew = 64;
          default: return r;
        endcase
        tfill = 1; base = -1;
      end
      4'd5: begin tfill = 1; base = -1; end
      4'd6: begin ew = 8; tfill = 1; tfrom = evl; end
      4'd8: begin tfill = v.vta; tfrom = 1; end
      4'd9: begin
        cnt = 0;
        for (int i = 0; i < int'(v.vl); i++) if (v.mask[i]) cnt++;
        tfill = v.vta; tfrom = cnt; base = -1;
      end
      default: return r;
    endcase
    if (bitwise) ew = 1;
    n = 128 / ew;
    if (base < 0) base = int'(v.roff) * n;
    for (int b = 0; b < 128; b++) begin
      g = base + b / ew;
      if (mfill && g >= int'(v.vstart) && g < int'(v.vl) && !(g < 128 && v.mask[g] == 1'b1) && g < 128)
        r[b] = 1'b1;
      if (tfill && g >= tfrom) r[b] = 1'b1;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_vd = v.vd; in_mask = v.mask; in_vl = v.vl; in_vstart = v.vstart;
    in_sew = v.sew; in_vm = v.vm; in_vma = v.vma; in_vta = v.vta;
    in_width = v.width; in_class = v.cls; in_roff = v.roff; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {127'b0, out_done}, 128'h0, "done after reset");
    check("R1", out_vd, 128'h0, "out_vd after reset");
    check("R1", {127'b0, in_ready}, 128'h1, "ready high");

    for (int k = 0; k < N; k++) begin
      apply(VECS[k]);
      check("R1", {127'b0, out_done}, 128'h1, "done one cycle after accept");
      check(TAGS[k], out_vd, expect_of(VECS[k]), $sformatf("table row %0d", k));
      if (k == 0) check("R4", out_vd, 128'h00000000_ffffffff_ffffffff_00000002, "mask fill literal");
      if (k == 4) check("R7", out_vd, 128'hffffffff_ffffffff_ffffffff_ffffc000, "mask tail literal");
      if (k == 6) check("R8", out_vd, 128'hffffffff_ffffffff_ffffffff_ff123456, "mask load literal");
      if (k == 9) check("R10", out_vd, 128'hffffffff_ffffffff_ffffffff_ff000000, "compress literal");
    end

    // R1: done is a single-cycle pulse
    @(negedge clk);
    check("R1", {127'b0, out_done}, 128'h0, "done falls when idle");

    // R6: offset 2 with SEW 16 puts elements 16..23 in this register; vl 19 -> 3 kept
    apply('{128'h0, 128'h0, 8'd19, 8'd0, 2'd1, 1'b1, 1'b0, 1'b1, 3'b000, 4'd0, 3'd2});
    check("R6", out_vd, 128'hffffffff_ffffffff_ffffffff_ffff0000 << 32, "offset tail");

    // R11: 64-bit strided load element width, vl 1, vta 0 still fills
    apply('{128'h5, 128'h0, 8'd1, 8'd0, 2'd0, 1'b1, 1'b0, 1'b0, 3'b111, 4'd4, 3'd0});
    check("R11", out_vd, {64'hffffffffffffffff, 64'h5}, "width 111 tail");

    // R9: scalar move with vta 0 is left alone
    apply('{128'h1234, 128'h0, 8'd4, 8'd0, 2'd1, 1'b1, 1'b0, 1'b0, 3'b000, 4'd8, 3'd0});
    check("R9", out_vd, 128'h1234, "scalar move undisturbed");

    finish_run();
  end
endmodule